// File: doc/BRIEF.md
# Memory Operation Metadata Disposition

This block sits between address generation and the memory port of a load/store unit. For every memory operation it receives the final address together with its metadata tag, the operation kind (load, store or address computation), and the store value with its tag for stores. From the tags it decides how the operation ends. It may go to memory. It may be silently dropped. It may fault. It may complete at once with a result the block builds itself.

Two markers travel with data. None stands for a missing operand. NaR stands for an operand that is not a result. A store that meets a None is discarded without a trace, while a NaR reaching a store raises a fault. Loads and address computations whose address carries a marker never reach memory. They return the marker straight away, copied into every element of an operand of the requested element width and shape. Operations that do go to memory first pass a protection check, which is issued in the same cycle as the memory request. A refusal turns into a fault with its own cause code.

One operation is in flight at a time, so completions appear in the order operations were accepted.

Top module: `mem_op_disposition`

## Requirements
- R1: While reset is low and in the first cycle after it, `in_ready` is 1 and `cmp_valid`, `mreq_valid` and `prot_chk_valid` are 0.
- R2: A store (`in_op` = 1) whose address tag or value tag has bit 0 set (None) completes with `cmp_status` = 2 (dropped), `cmp_fault` = 0, and issues neither a memory request nor a protection check.
- R3: A store with no None tag but with tag 2'b10 (NaR) on the address or the value completes with `cmp_status` = 3, `cmp_fault` = 1, and issues no memory request.
- R4: None is tested before NaR: a store carrying a None on one operand and a NaR on the other is dropped as in R2, and tag 2'b11 counts as None.
- R5: A store with two normal (2'b00) tags raises `prot_chk_valid` with `prot_addr` equal to the address and `prot_write` = 1. It raises `mreq_valid` with `mreq_write` = 1, the address and the value. It completes with `cmp_status` = 1 in the cycle after the handshake.
- R6: When `prot_deny` is high during the protection check of a load or store, no memory request is issued and the operation completes in the next cycle with `cmp_status` = 4 and `cmp_fault` = 1.
- R7: An address computation (`in_op` = 2 or 3) never reaches memory. It completes with `cmp_status` = 0, bytes 0..7 of `cmp_data` holding the address, tag slot 0 holding the address marker (01 None, 10 NaR, 00 normal), and all other bytes and tags zero.
- R8: A load (`in_op` = 0) whose address is None or NaR skips memory and completes with `cmp_status` = 0. Every active element holds the address marker tag, and its data is the address truncated to the element width of 1 << `in_ew` bytes. Active elements are element 0 for a scalar (`in_vec` = 0) and all 32 >> `in_ew` elements for a vector. Inactive bytes and tags are zero.
- R9: A load with a normal address issues a read request carrying the address, `mreq_ew` and `mreq_vec`. On `mrsp_valid` it completes with `cmp_status` = 0, the response bytes of the active elements (R8's rule), and all tags 2'b00.
- R10: Operations that do not go to memory complete with `cmp_valid` high in the cycle right after acceptance.
- R11: From acceptance of a memory-bound operation until its completion, `in_ready` is 0.
- R12: A memory request that is not accepted stays asserted with the same address until `mreq_ready`, unless the protection check refuses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can accept an operation |
| in_op | input | 2 | 0 load, 1 store, 2 or 3 address computation |
| in_addr_tag | input | 2 | Address tag: bit 0 None, bit 1 NaR |
| in_addr | input | PTR_W | Final address or marker payload |
| in_val_tag | input | 2 | Store value tag |
| in_val | input | PTR_W | Store value |
| in_ew | input | 2 | Log2 of load element bytes |
| in_vec | input | 1 | Load shape: 1 vector, 0 scalar |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory port accepts request |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_addr | output | PTR_W | Request address |
| mreq_wdata | output | PTR_W | Write data |
| mreq_ew | output | 2 | Element width code |
| mreq_vec | output | 1 | Vector shape |
| mrsp_valid | input | 1 | Load data returned |
| mrsp_data | input | 8*OPND_BYTES | Load data |
| prot_chk_valid | output | 1 | Protection check request |
| prot_addr | output | PTR_W | Address to check |
| prot_write | output | 1 | Access is a write |
| prot_deny | input | 1 | Protection refuses the access |
| cmp_valid | output | 1 | Completion pulse |
| cmp_status | output | 3 | 0 data, 1 stored, 2 dropped, 3 NaR fault, 4 protection fault |
| cmp_fault | output | 1 | Completion is a fault |
| cmp_data | output | 8*OPND_BYTES | Result operand |
| cmp_tags | output | 2*OPND_BYTES | Per-element tags, element i at bits 2i+1:2i |

## Verification
The bench builds the block with its defaults: a 64-bit pointer and a 32-byte operand. Under these values all four element widths give full vectors of 32, 16, 8 and 4 elements, and marker payloads are truncated to 1, 2 and 4 bytes as well as kept whole at 8. The 64-bit payload also exercises the byte-slot replication across every element. Randomly withheld `mreq_ready` and delayed responses bring the request-hold and busy windows within reach.

// File: rtl/mop_pkg.sv
// Package: shared codes for the memory operation disposition block.
// Assumes tags are 2 bits with bit 0 = None and bit 1 = NaR; None wins.
package mop_pkg;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;

    localparam logic [1:0] TAG_NORMAL = 2'b00;
    localparam logic [1:0] TAG_NONE   = 2'b01;
    localparam logic [1:0] TAG_NAR    = 2'b10;

    typedef enum logic [1:0] {
        DISP_MEM    = 2'd0,
        DISP_RESULT = 2'd1,
        DISP_DROP   = 2'd2,
        DISP_NARFLT = 2'd3
    } disp_e;

    typedef enum logic [2:0] {
        ST_DATA     = 3'd0,
        ST_STORED   = 3'd1,
        ST_DROPPED  = 3'd2,
        ST_NAR_FLT  = 3'd3,
        ST_PROT_FLT = 3'd4
    } status_e;

endpackage

// File: rtl/mop_classify.sv
// Module: mop_classify
// Decides the disposition of an offered operation from its kind and tags,
// and produces the normalised marker carried by the address.
// Assumes: purely combinational; None is tested before NaR everywhere.
module mop_classify
    import mop_pkg::*;
(
    input  logic [1:0] op,
    input  logic [1:0] addr_tag,
    input  logic [1:0] val_tag,
    output disp_e      disp,
    output logic [1:0] marker_tag
);

    logic a_none, a_nar, v_none, v_nar;

    // Split tags into marker flags with None priority.
    always_comb begin
        a_none = addr_tag[0];
        a_nar  = addr_tag[1] & ~addr_tag[0];
        v_none = val_tag[0];
        v_nar  = val_tag[1] & ~val_tag[0];
    end

    // Normalised address marker for result building.
    always_comb begin
        if (a_none)     marker_tag = TAG_NONE;
        else if (a_nar) marker_tag = TAG_NAR;
        else            marker_tag = TAG_NORMAL;
    end

    // Disposition decision per operation kind.
    always_comb begin
        if (op[1]) begin
            disp = DISP_RESULT;
        end else if (op == OP_STORE) begin
            if (a_none | v_none)     disp = DISP_DROP;
            else if (a_nar | v_nar)  disp = DISP_NARFLT;
            else                     disp = DISP_MEM;
        end else begin
            disp = (a_none | a_nar) ? DISP_RESULT : DISP_MEM;
        end
    end

endmodule

// File: rtl/mop_operand_build.sv
// Module: mop_operand_build
// Builds a result operand: either a marker payload replicated into every
// active element (truncated to the element width) or memory data masked
// to the active elements.
// Assumes: PTR_W <= 64, element widths of 1..8 bytes, OPND_BYTES a power of 2
// and at least 8.
module mop_operand_build
    import mop_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int OPND_BYTES = 32
) (
    input  logic [PTR_W-1:0]        payload,
    input  logic [1:0]              tag,
    input  logic [1:0]              ew,
    input  logic                    vec,
    input  logic                    from_mem,
    input  logic [8*OPND_BYTES-1:0] mem_data,
    output logic [8*OPND_BYTES-1:0] data,
    output logic [2*OPND_BYTES-1:0] tags
);

    localparam int ELEMS = OPND_BYTES;

    logic [3:0]  eb;
    logic [63:0] pay64;

    assign eb    = 4'd1 << ew;
    assign pay64 = 64'(payload);

    // Per byte: pick memory byte or the payload byte at its slot in the element.
    for (genvar j = 0; j < OPND_BYTES; j++) begin : g_byte
        logic [2:0] slot;
        logic       act;
        assign slot = 3'(j) & 3'(eb - 4'd1);
        assign act  = vec || (32'(j) < 32'(eb));
        assign data[8*j +: 8] = !act     ? 8'h00 :
                                from_mem ? mem_data[8*j +: 8] :
                                           pay64[8*slot +: 8];
    end

    // Per element: active elements carry the marker, the rest stay normal.
    for (genvar i = 0; i < ELEMS; i++) begin : g_elem
        logic act;
        assign act = vec ? (32'(i) < (32'(ELEMS) >> ew)) : (i == 0);
        assign tags[2*i +: 2] = (act && !from_mem) ? tag : TAG_NORMAL;
    end

endmodule

// File: rtl/mop_mem_seq.sv
// Module: mop_mem_seq
// Sequences one memory-bound operation: protection check and request in the
// same cycle, then (for loads) waiting for the response.
// Assumes: start only arrives while idle; the protection answer is
// combinational in the request cycle.
module mop_mem_seq
    import mop_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_write,
    input  logic [PTR_W-1:0] start_addr,
    input  logic [PTR_W-1:0] start_val,
    input  logic [1:0]       start_ew,
    input  logic             start_vec,
    input  logic             mreq_ready,
    input  logic             prot_deny,
    input  logic             mrsp_valid,
    output logic             idle,
    output logic             waiting,
    output logic             mreq_valid,
    output logic             mreq_write,
    output logic [PTR_W-1:0] mreq_addr,
    output logic [PTR_W-1:0] mreq_wdata,
    output logic [1:0]       mreq_ew,
    output logic             mreq_vec,
    output logic             prot_chk_valid,
    output logic             done_store,
    output logic             done_prot,
    output logic             done_load
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_e;

    seq_state_e       state_q;
    logic             write_q;
    logic [PTR_W-1:0] addr_q, val_q;
    logic [1:0]       ew_q;
    logic             vec_q;

    // State progression through request and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) state_q <= SQ_REQ;
                SQ_REQ: begin
                    if (prot_deny)       state_q <= SQ_IDLE;
                    else if (mreq_ready) state_q <= write_q ? SQ_IDLE : SQ_WAIT;
                end
                SQ_WAIT: if (mrsp_valid) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture the operation fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            val_q   <= '0;
            ew_q    <= 2'd0;
            vec_q   <= 1'b0;
        end else if (start && state_q == SQ_IDLE) begin
            write_q <= start_write;
            addr_q  <= start_addr;
            val_q   <= start_val;
            ew_q    <= start_ew;
            vec_q   <= start_vec;
        end
    end

    assign idle           = (state_q == SQ_IDLE);
    assign waiting        = (state_q == SQ_WAIT);
    assign prot_chk_valid = (state_q == SQ_REQ);
    assign mreq_valid     = (state_q == SQ_REQ) && !prot_deny;
    assign mreq_write     = write_q;
    assign mreq_addr      = addr_q;
    assign mreq_wdata     = val_q;
    assign mreq_ew        = ew_q;
    assign mreq_vec       = vec_q;
    assign done_prot      = (state_q == SQ_REQ) && prot_deny;
    assign done_store     = (state_q == SQ_REQ) && !prot_deny && mreq_ready && write_q;
    assign done_load      = (state_q == SQ_WAIT) && mrsp_valid;

    // R12: a stalled request holds its address and direction.
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |=> (mreq_valid || prot_deny)
                                      && $stable(mreq_addr) && $stable(mreq_write));

endmodule

// File: rtl/mem_op_disposition.sv
// Module: mem_op_disposition (top)
// Accepts one memory operation at a time, classifies it by its tags and
// either completes it immediately (marker result, drop, NaR fault) or runs it
// through protection check and memory port. Completion is a registered pulse.
// Assumes: completion consumer never stalls; one operation in flight.
module mem_op_disposition
    import mop_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int OPND_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_op,
    input  logic [1:0]              in_addr_tag,
    input  logic [PTR_W-1:0]        in_addr,
    input  logic [1:0]              in_val_tag,
    input  logic [PTR_W-1:0]        in_val,
    input  logic [1:0]              in_ew,
    input  logic                    in_vec,
    output logic                    mreq_valid,
    input  logic                    mreq_ready,
    output logic                    mreq_write,
    output logic [PTR_W-1:0]        mreq_addr,
    output logic [PTR_W-1:0]        mreq_wdata,
    output logic [1:0]              mreq_ew,
    output logic                    mreq_vec,
    input  logic                    mrsp_valid,
    input  logic [8*OPND_BYTES-1:0] mrsp_data,
    output logic                    prot_chk_valid,
    output logic [PTR_W-1:0]        prot_addr,
    output logic                    prot_write,
    input  logic                    prot_deny,
    output logic                    cmp_valid,
    output logic [2:0]              cmp_status,
    output logic                    cmp_fault,
    output logic [8*OPND_BYTES-1:0] cmp_data,
    output logic [2*OPND_BYTES-1:0] cmp_tags
);

    localparam int         OPND_W = 8 * OPND_BYTES;
    localparam int         TAGS_W = 2 * OPND_BYTES;
    localparam logic [1:0] PTR_EW = 2'($clog2(PTR_W / 8));

    disp_e             disp;
    logic [1:0]        marker_tag;
    logic              accept, start;
    logic              seq_idle, seq_wait;
    logic              done_store, done_prot, done_load;
    logic [1:0]        b_ew;
    logic              b_vec;
    logic [OPND_W-1:0] b_data;
    logic [TAGS_W-1:0] b_tags;
    status_e           nxt_status;
    logic              nxt_valid, nxt_has_data;

    mop_classify u_cls (
        .op         (in_op),
        .addr_tag   (in_addr_tag),
        .val_tag    (in_val_tag),
        .disp       (disp),
        .marker_tag (marker_tag)
    );

    assign in_ready = seq_idle;
    assign accept   = in_valid && seq_idle;
    assign start    = accept && (disp == DISP_MEM);

    mop_mem_seq #(.PTR_W(PTR_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_write    (in_op == OP_STORE),
        .start_addr     (in_addr),
        .start_val      (in_val),
        .start_ew       (in_ew),
        .start_vec      (in_vec),
        .mreq_ready     (mreq_ready),
        .prot_deny      (prot_deny),
        .mrsp_valid     (mrsp_valid),
        .idle           (seq_idle),
        .waiting        (seq_wait),
        .mreq_valid     (mreq_valid),
        .mreq_write     (mreq_write),
        .mreq_addr      (mreq_addr),
        .mreq_wdata     (mreq_wdata),
        .mreq_ew        (mreq_ew),
        .mreq_vec       (mreq_vec),
        .prot_chk_valid (prot_chk_valid),
        .done_store     (done_store),
        .done_prot      (done_prot),
        .done_load      (done_load)
    );

    assign prot_addr  = mreq_addr;
    assign prot_write = mreq_write;

    // Shape for the shared builder: captured shape on load return, else offered.
    always_comb begin
        if (seq_wait) begin
            b_ew  = mreq_ew;
            b_vec = mreq_vec;
        end else if (in_op[1]) begin
            b_ew  = PTR_EW;
            b_vec = 1'b0;
        end else begin
            b_ew  = in_ew;
            b_vec = in_vec;
        end
    end

    mop_operand_build #(.PTR_W(PTR_W), .OPND_BYTES(OPND_BYTES)) u_build (
        .payload  (in_addr),
        .tag      (marker_tag),
        .ew       (b_ew),
        .vec      (b_vec),
        .from_mem (seq_wait),
        .mem_data (mrsp_data),
        .data     (b_data),
        .tags     (b_tags)
    );

    // Completion status selection for this cycle.
    always_comb begin
        nxt_valid    = (accept && disp != DISP_MEM) || done_store || done_prot || done_load;
        nxt_has_data = done_load || (accept && disp == DISP_RESULT);
        if (done_prot)       nxt_status = ST_PROT_FLT;
        else if (done_store) nxt_status = ST_STORED;
        else if (done_load)  nxt_status = ST_DATA;
        else begin
            case (disp)
                DISP_DROP:   nxt_status = ST_DROPPED;
                DISP_NARFLT: nxt_status = ST_NAR_FLT;
                default:     nxt_status = ST_DATA;
            endcase
        end
    end

    // Registered completion pulse and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_valid  <= 1'b0;
            cmp_status <= 3'd0;
            cmp_fault  <= 1'b0;
            cmp_data   <= '0;
            cmp_tags   <= '0;
        end else begin
            cmp_valid  <= nxt_valid;
            cmp_status <= nxt_status;
            cmp_fault  <= (nxt_status == ST_NAR_FLT) || (nxt_status == ST_PROT_FLT);
            cmp_data   <= nxt_has_data ? b_data : '0;
            cmp_tags   <= nxt_has_data ? b_tags : '0;
        end
    end

    // R2/R4: a None on either store operand drops it without memory traffic.
    assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_op == OP_STORE && (in_addr_tag[0] || in_val_tag[0])
        |=> cmp_valid && cmp_status == 3'd2 && !cmp_fault && !mreq_valid);

    // R3: NaR without None on a store faults.
    assert_nar_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_op == OP_STORE && !(in_addr_tag[0] || in_val_tag[0])
               && (in_addr_tag[1] || in_val_tag[1])
        |=> cmp_valid && cmp_fault && cmp_status == 3'd3);

    // R6: a refused protection check ends the operation with a fault.
    assert_prot_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_chk_valid && prot_deny |=> cmp_valid && cmp_fault && cmp_status == 3'd4 && in_ready);

    // R7: address computation returns the address in element 0.
    assert_lea_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_op[1] |=> cmp_data[PTR_W-1:0] == $past(in_addr)
                               && cmp_tags[TAGS_W-1:2] == '0);

    // R10: non-memory operations finish in the next cycle.
    assert_fast_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && disp != DISP_MEM |=> cmp_valid);

    // R11: a memory-bound operation blocks new acceptance.
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !in_ready && !cmp_valid);

endmodule

// File: tb/mem_op_disposition_tb.sv
// Bench: directed corner cases then seeded random operations, each checked
// against expected values computed from the requirements.
module mem_op_disposition_tb_top;

    localparam int PW = 64;
    localparam int OB = 32;
    localparam int WD = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_op = 2'd0, in_addr_tag = 2'd0, in_val_tag = 2'd0, in_ew = 2'd0;
    logic [PW-1:0] in_addr = '0, in_val = '0;
    logic          in_vec = 1'b0;
    logic          mreq_valid, mreq_write, mreq_vec;
    logic          mreq_ready = 1'b0;
    logic [PW-1:0] mreq_addr, mreq_wdata, prot_addr;
    logic [1:0]    mreq_ew;
    logic          mrsp_valid = 1'b0;
    logic [8*OB-1:0] mrsp_data = '0;
    logic          prot_chk_valid, prot_write;
    logic          prot_deny = 1'b0;
    logic          cmp_valid, cmp_fault;
    logic [2:0]    cmp_status;
    logic [8*OB-1:0] cmp_data;
    logic [2*OB-1:0] cmp_tags;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mem_op_disposition #(.PTR_W(PW), .OPND_BYTES(OB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr_tag(in_addr_tag), .in_addr(in_addr),
        .in_val_tag(in_val_tag), .in_val(in_val), .in_ew(in_ew), .in_vec(in_vec),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
        .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata), .mreq_ew(mreq_ew),
        .mreq_vec(mreq_vec), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
        .prot_chk_valid(prot_chk_valid), .prot_addr(prot_addr),
        .prot_write(prot_write), .prot_deny(prot_deny), .cmp_valid(cmp_valid),
        .cmp_status(cmp_status), .cmp_fault(cmp_fault), .cmp_data(cmp_data),
        .cmp_tags(cmp_tags)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Expected operand: marker replicated per element, or response masked.
    function automatic void fill(input logic [63:0] pay, input logic [1:0] t,
                                 input logic [1:0] ew, input logic vec,
                                 input logic use_rsp, input logic [255:0] rsp,
                                 output logic [255:0] d, output logic [63:0] tg);
        int eb = 1 << ew;
        int n  = vec ? (32 / eb) : 1;
        d  = '0;
        tg = '0;
        for (int j = 0; j < 32; j++)
            if (vec || j < eb) d[8*j +: 8] = use_rsp ? rsp[8*j +: 8] : pay[8*(j % eb) +: 8];
        for (int i = 0; i < n; i++)
            tg[2*i +: 2] = use_rsp ? 2'b00 : t;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [1:0] at, input logic [63:0] a,
                          input logic [1:0] vt, input logic [63:0] v,
                          input logic [1:0] ew, input logic vec, input logic deny);
        logic a_none, a_nar, v_none, v_nar, exp_mem;
        logic [1:0]   mtag;
        logic [2:0]   exp_st, got_st;
        logic [255:0] exp_d, got_d, rsp;
        logic [63:0]  exp_t, got_t;
        logic         got_f;
        string        rq;
        bit got, seen_req, seen_chk, bad_req, bad_chk, busy_bad, hold_bad, stalled, armed;
        int lat, delay;

        a_none = at[0]; a_nar = at[1] & ~at[0];
        v_none = vt[0]; v_nar = vt[1] & ~vt[0];
        mtag   = a_none ? 2'b01 : (a_nar ? 2'b10 : 2'b00);
        rsp    = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        exp_d  = '0; exp_t = '0;
        if (op[1]) begin
            exp_mem = 0; exp_st = 3'd0; rq = "R7";
            fill(a, mtag, 2'd3, 1'b0, 1'b0, '0, exp_d, exp_t);
        end else if (op == 2'd1) begin
            if (a_none | v_none) begin
                exp_mem = 0; exp_st = 3'd2;
                rq = ((a_none & v_nar) | (v_none & a_nar) | (at == 2'b11)) ? "R4" : "R2";
            end else if (a_nar | v_nar) begin
                exp_mem = 0; exp_st = 3'd3; rq = "R3";
            end else begin
                exp_mem = 1; exp_st = deny ? 3'd4 : 3'd1; rq = deny ? "R6" : "R5";
            end
        end else if (a_none | a_nar) begin
            exp_mem = 0; exp_st = 3'd0; rq = "R8";
            fill(a, mtag, ew, vec, 1'b0, '0, exp_d, exp_t);
        end else begin
            exp_mem = 1; exp_st = deny ? 3'd4 : 3'd0; rq = deny ? "R6" : "R9";
            if (!deny) fill(a, 2'b00, ew, vec, 1'b1, rsp, exp_d, exp_t);
        end

        chk(in_ready == 1'b1, "R11", "idle before offer", 256'(in_ready), 256'(1));
        in_op = op; in_addr_tag = at; in_addr = a; in_val_tag = vt; in_val = v;
        in_ew = ew; in_vec = vec; prot_deny = deny; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;

        got = 0; seen_req = 0; seen_chk = 0; bad_req = 0; bad_chk = 0;
        busy_bad = 0; hold_bad = 0; stalled = 0; armed = 0; lat = 0; delay = 0;
        got_st = '0; got_d = '0; got_t = '0; got_f = 0;
        for (int cyc = 0; cyc < 64 && !got; cyc++) begin
            if (cmp_valid) begin
                got = 1; lat = cyc;
                got_st = cmp_status; got_d = cmp_data; got_t = cmp_tags; got_f = cmp_fault;
                mrsp_valid = 1'b0; mreq_ready = 1'b0;
            end else begin
                if (in_ready) busy_bad = 1;
                if (stalled && !deny && !(mreq_valid && mreq_addr == a)) hold_bad = 1;
                mrsp_valid = 1'b0;
                if (armed) begin
                    if (delay == 0) begin
                        mrsp_valid = 1'b1; mrsp_data = rsp; armed = 0;
                    end else delay--;
                end
                if (prot_chk_valid) begin
                    seen_chk = 1;
                    if (prot_addr != a || prot_write != (op == 2'd1)) bad_chk = 1;
                end
                if (mreq_valid) begin
                    seen_req = 1;
                    if (mreq_addr != a || mreq_write != (op == 2'd1)) bad_req = 1;
                    if (op == 2'd1 && mreq_wdata != v) bad_req = 1;
                    if (op == 2'd0 && (mreq_ew != ew || mreq_vec != vec)) bad_req = 1;
                    mreq_ready = ($urandom % 3) != 0;
                    stalled = !mreq_ready;
                    if (mreq_ready && op == 2'd0) begin
                        armed = 1; delay = $urandom % 3;
                    end
                end else begin
                    mreq_ready = 1'b0;
                    stalled = 0;
                end
                @(negedge clk);
            end
        end

        chk(got, rq, "completion seen", 256'(got), 256'(1));
        chk(got_st == exp_st, rq, "status", 256'(got_st), 256'(exp_st));
        chk(got_f == (exp_st >= 3'd3), rq, "fault flag", 256'(got_f), 256'(exp_st >= 3'd3));
        chk(got_d == exp_d, rq, "data", got_d, exp_d);
        chk(got_t == exp_t, rq, "tags", 256'(got_t), 256'(exp_t));
        if (!exp_mem) begin
            chk(lat == 0, "R10", "latency", 256'(lat), 256'(0));
            chk(!seen_req && !seen_chk, rq, "no memory traffic", 256'({seen_req, seen_chk}), 256'(0));
        end else begin
            chk(seen_chk && !bad_chk, "R5", "protection request", 256'({seen_chk, bad_chk}), 256'(2));
            if (deny) chk(!seen_req, "R6", "request blocked", 256'(seen_req), 256'(0));
            else      chk(seen_req && !bad_req, rq, "request fields", 256'({seen_req, bad_req}), 256'(2));
            chk(!busy_bad, "R11", "not ready while busy", 256'(busy_bad), 256'(0));
            chk(!hold_bad, "R12", "stalled request held", 256'(hold_bad), 256'(0));
        end
        @(negedge clk);
    endtask

    function automatic logic [1:0] rnd_tag();
        int r = $urandom % 6;
        return (r < 3) ? 2'b00 : (r == 3) ? 2'b01 : (r == 4) ? 2'b10 : 2'b11;
    endfunction

    initial begin
        repeat (WD) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cmp_valid == 0 && mreq_valid == 0 && prot_chk_valid == 0 && in_ready == 1,
            "R1", "in reset", 256'({cmp_valid, mreq_valid, prot_chk_valid, in_ready}), 256'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmp_valid == 0 && mreq_valid == 0 && prot_chk_valid == 0 && in_ready == 1,
            "R1", "after reset", 256'({cmp_valid, mreq_valid, prot_chk_valid, in_ready}), 256'(1));

        base = 64'h8877_6655_4433_2211;
        run_op(2'd1, 2'b01, base, 2'b00, 64'h5, 2'd3, 1'b0, 1'b0); // R2 None address
        run_op(2'd1, 2'b00, base, 2'b01, 64'h5, 2'd3, 1'b0, 1'b0); // R2 None value
        run_op(2'd1, 2'b10, base, 2'b00, 64'h5, 2'd3, 1'b0, 1'b0); // R3 NaR address
        run_op(2'd1, 2'b00, base, 2'b10, 64'h5, 2'd3, 1'b0, 1'b0); // R3 NaR value
        run_op(2'd1, 2'b01, base, 2'b10, 64'h5, 2'd3, 1'b0, 1'b0); // R4 None beats NaR
        run_op(2'd1, 2'b10, base, 2'b01, 64'h5, 2'd3, 1'b0, 1'b0); // R4 other side
        run_op(2'd1, 2'b11, base, 2'b00, 64'h5, 2'd3, 1'b0, 1'b0); // R4 tag 11 is None
        run_op(2'd1, 2'b00, base, 2'b00, 64'hdead_beef_0bad_f00d, 2'd3, 1'b0, 1'b0); // R5
        run_op(2'd1, 2'b00, base, 2'b00, 64'h1234, 2'd3, 1'b0, 1'b1); // R6 store denied
        run_op(2'd2, 2'b01, base, 2'b00, 64'h0, 2'd0, 1'b0, 1'b0);    // R7 None
        run_op(2'd3, 2'b10, base, 2'b00, 64'h0, 2'd0, 1'b1, 1'b0);    // R7 NaR
        run_op(2'd2, 2'b00, base, 2'b00, 64'h0, 2'd1, 1'b1, 1'b0);    // R7 normal
        run_op(2'd0, 2'b01, base, 2'b00, 64'h0, 2'd0, 1'b1, 1'b0);    // R8 32 x 1 byte
        run_op(2'd0, 2'b10, base, 2'b00, 64'h0, 2'd2, 1'b0, 1'b0);    // R8 scalar 4 bytes
        run_op(2'd0, 2'b10, base, 2'b00, 64'h0, 2'd3, 1'b1, 1'b0);    // R8 4 x 8 bytes
        run_op(2'd0, 2'b01, base, 2'b00, 64'h0, 2'd1, 1'b1, 1'b0);    // R8 16 x 2 bytes
        run_op(2'd0, 2'b00, base, 2'b00, 64'h0, 2'd1, 1'b1, 1'b0);    // R9 vector load
        run_op(2'd0, 2'b00, base, 2'b00, 64'h0, 2'd0, 1'b0, 1'b0);    // R9 scalar byte
        run_op(2'd0, 2'b00, base, 2'b00, 64'h0, 2'd2, 1'b1, 1'b1);    // R6 load denied

        for (int k = 0; k < 200; k++) begin
            run_op(2'($urandom % 4), rnd_tag(), {$urandom, $urandom}, rnd_tag(),
                   {$urandom, $urandom}, 2'($urandom % 4), 1'($urandom % 2),
                   ($urandom % 6) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule